// File: doc/BRIEF.md
# Serial Bitstream Input Receiver

This block accepts a compressed audio stream from an external source over three wires: a serial clock, a serial data line and a bit-enable qualifier. All three pins are brought into the system clock domain through a synchroniser. Each qualified edge of the serial clock shifts one data bit into a byte, most significant bit first. Each completed byte leaves on a byte-wide bus with a one-cycle valid strobe, ready to be written into the input buffer.

The block keeps a count of how many entries of the input buffer are in use. The count goes up on every byte delivered and down on every pop from the buffer's consumer. From that count it drives a data-request pin that tells the source whether it may keep sending. The request has hysteresis: it is withdrawn when the buffer is nearly full and granted again only after a larger amount of room has been freed. Two control inputs, normally held by a register bank, select the capture edge of the serial clock and the active level of the request pin.

Top module: `bitstream_rx`

## Requirements
- R1: During and right after reset, `buf_level` is 0, `byte_valid` is low, and the request is granted (`data_req` is 1 when `cfg_req_inv` is 0).
- R2: When bit 2 of `cfg_clk_pol` is 0, data is captured on the rising edge of `ser_clk`, and the falling edge captures nothing.
- R3: When bit 2 of `cfg_clk_pol` is 1, data is captured on the falling edge of `ser_clk`. Control value 0x04 selects this mode. The other seven bits of `cfg_clk_pol` have no effect.
- R4: A capture edge that occurs while `ser_bit_en` is 0 shifts no bit in and does not advance the bit count.
- R5: Bits are assembled most significant bit first. After every eighth captured bit, `byte_valid` is high for exactly one cycle with the byte on `byte_data`.
- R6: `buf_level` rises by 1 for each delivered byte and falls by 1 for each cycle with `buf_pop` high. A pop while the level is 0 is ignored. A byte and a pop in the same cycle leave the level unchanged when it is nonzero. The level never exceeds the buffer depth of 256.
- R7: The request is withdrawn once free space (256 minus `buf_level`) is 4 or less, and it stays granted while free space is 5 or more and the request was already granted.
- R8: Once withdrawn, the request stays withdrawn while free space is below 32, and it is granted again when free space reaches 32.
- R9: With `cfg_req_inv` at 0 the pin is high when sending is allowed. With `cfg_req_inv` at 1 the pin is low when sending is allowed.
- R10: Reset discards a partially assembled byte, so the next eight captured bits form a whole byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock from the source |
| ser_data | input | 1 | Serial data line |
| ser_bit_en | input | 1 | Bit qualifier; 1 means the current bit is valid |
| cfg_clk_pol | input | 8 | Edge control; bit 2 set selects falling-edge capture |
| cfg_req_inv | input | 1 | 1 makes the request pin active low |
| buf_pop | input | 1 | One buffer entry consumed in this cycle |
| byte_data | output | 8 | Assembled byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| buf_level | output | 9 | Buffer entries in use |
| data_req | output | 1 | Request pin to the source |

## Verification
The push of a freshly assembled byte and a pop from the buffer's consumer can land on the same clock edge. Both update the level counter. The bench provokes this by watching for `byte_valid` and raising `buf_pop` so that it is sampled on the same edge. It does this once with a nonzero level and once with an empty buffer. The level is judged afterwards: it stays unchanged in the first case and rises to 1 in the second, because a pop on an empty buffer is dropped even when a byte arrives with it.

// File: rtl/bitstream_rx_pkg.sv
// Shared constants and types for the serial bitstream receiver.
package bitstream_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    // Which serial clock transition captures a bit.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } cap_edge_e;
endpackage

// File: rtl/bitstream_rx_sync.sv
// Multi-stage synchroniser for a group of asynchronous pins.
// Assumes pins are slow against clk (each level held >= 2 clk cycles).
// Gives the synchronised value and the value one cycle older for edge detection.
module bitstream_rx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_s,
    output logic [W-1:0] pin_d
);
    localparam int DEPTH_ALL = STAGES + 1;

    logic [W-1:0] stg [DEPTH_ALL];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH_ALL; gi++) begin : g_stage
            // Purpose: move the pins one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= '0;
                else if (gi == 0) stg[gi] <= pin_in;
                else stg[gi] <= stg[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign pin_s = stg[STAGES-1];
    assign pin_d = stg[STAGES];
endmodule

// File: rtl/bitstream_rx_pack.sv
// Detects the selected serial clock edge and packs qualified bits MSB first.
// Assumes synchronised inputs; at most one capture per two clk cycles.
module bitstream_rx_pack
    import bitstream_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sclk_d,
    input  logic              data_s,
    input  logic              en_s,
    input  cap_edge_e         edge_sel,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic [CNT_W-1:0]  bit_cnt
);
    logic              edge_hit;
    logic              cap;
    logic [BYTE_W-1:0] shreg;

    // Purpose: pick the capture transition and gate it with the qualifier.
    always_comb begin
        if (edge_sel == EDGE_FALL) edge_hit = sclk_d & ~sclk_s;
        else                       edge_hit = ~sclk_d & sclk_s;
        cap = edge_hit & en_s;
    end

    // Purpose: shift bits in and publish each completed byte for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (cap) begin
                shreg <= {shreg[BYTE_W-2:0], data_s};
                if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                    byte_data  <= {shreg[BYTE_W-2:0], data_s};
                    byte_valid <= 1'b1;
                    bit_cnt    <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bitstream_rx_level.sv
// Tracks input-buffer occupancy and derives the send permission with hysteresis.
// Assumes STOP_FREE < RESUME_FREE <= DEPTH.
module bitstream_rx_level #(
    parameter int DEPTH       = 256,
    parameter int STOP_FREE   = 4,
    parameter int RESUME_FREE = 32,
    localparam int LVL_W      = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [LVL_W-1:0] level,
    output logic             req_active
);
    logic             pop_ok;
    logic             push_ok;
    logic [LVL_W-1:0] free_cnt;

    // Purpose: decide which occupancy changes take effect this cycle.
    always_comb begin
        pop_ok   = pop && (level != '0);
        push_ok  = push && ((level != LVL_W'(DEPTH)) || pop_ok);
        free_cnt = LVL_W'(DEPTH) - level;
    end

    // Purpose: update the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else if (push_ok && !pop_ok) level <= level + 1'b1;
        else if (pop_ok && !push_ok) level <= level - 1'b1;
    end

    // Purpose: withdraw near full, grant again once enough room is back.
    always_ff @(posedge clk) begin
        if (!rst_n) req_active <= 1'b1;
        else if (free_cnt <= LVL_W'(STOP_FREE)) req_active <= 1'b0;
        else if (free_cnt >= LVL_W'(RESUME_FREE)) req_active <= 1'b1;
    end
endmodule

// File: rtl/bitstream_rx.sv
// Top of the serial bitstream receiver: synchroniser, byte packer, level tracker.
// Assumes the serial clock is at most a quarter of clk and the config is quasi-static.
module bitstream_rx
    import bitstream_rx_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int STOP_FREE   = 4,
    parameter int RESUME_FREE = 32,
    parameter int SYNC_STAGES = 2,
    parameter int POL_BIT     = 2,
    localparam int LVL_W      = $clog2(DEPTH+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_bit_en,
    input  logic [7:0]        cfg_clk_pol,
    input  logic              cfg_req_inv,
    input  logic              buf_pop,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic [LVL_W-1:0]  buf_level,
    output logic              data_req
);
    logic [2:0]       pins_s;
    logic [2:0]       pins_d;
    logic [CNT_W-1:0] bit_cnt;
    logic             req_active;
    cap_edge_e        edge_sel;
    logic             unused_pol_bits;

    assign edge_sel        = cap_edge_e'(cfg_clk_pol[POL_BIT]);
    assign unused_pol_bits = ^cfg_clk_pol;

    bitstream_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in ({ser_bit_en, ser_data, ser_clk}),
        .pin_s  (pins_s),
        .pin_d  (pins_d)
    );

    bitstream_rx_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[0]),
        .sclk_d     (pins_d[0]),
        .data_s     (pins_s[1]),
        .en_s       (pins_s[2]),
        .edge_sel   (edge_sel),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .bit_cnt    (bit_cnt)
    );

    bitstream_rx_level #(
        .DEPTH(DEPTH), .STOP_FREE(STOP_FREE), .RESUME_FREE(RESUME_FREE)
    ) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (byte_valid),
        .pop        (buf_pop),
        .level      (buf_level),
        .req_active (req_active)
    );

    // Purpose: apply the programmed pin polarity to the send permission.
    always_comb data_req = req_active ^ cfg_req_inv;
endmodule

// File: rtl/bitstream_rx_chk.sv
// Property checker for bitstream_rx, attached by bind.
module bitstream_rx_chk #(
    parameter int DEPTH       = 256,
    parameter int STOP_FREE   = 4,
    parameter int RESUME_FREE = 32,
    parameter int LVL_W       = 9,
    parameter int CNT_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic             buf_pop,
    input logic [LVL_W-1:0] buf_level,
    input logic             req_active,
    input logic [CNT_W-1:0] bit_cnt
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R5

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        buf_level <= LVL_W'(DEPTH)); // R6

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_level == $past(buf_level)) || (buf_level == $past(buf_level) + 1'b1)
        || (buf_level + 1'b1 == $past(buf_level))); // R6

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_level == '0 && buf_pop && !byte_valid) |=> (buf_level == '0)); // R6

    AST_REQ_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_level >= LVL_W'(DEPTH - STOP_FREE)) |=> !req_active); // R7

    AST_REQ_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_level <= LVL_W'(DEPTH - RESUME_FREE)) |=> req_active); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_level > LVL_W'(DEPTH - RESUME_FREE) && buf_level < LVL_W'(DEPTH - STOP_FREE))
        |=> (req_active == $past(req_active))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (bit_cnt == '0 && !byte_valid && buf_level == '0)); // R10
endmodule

bind bitstream_rx bitstream_rx_chk #(
    .DEPTH(DEPTH), .STOP_FREE(STOP_FREE), .RESUME_FREE(RESUME_FREE),
    .LVL_W(LVL_W), .CNT_W(bitstream_rx_pkg::CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .buf_pop    (buf_pop),
    .buf_level  (buf_level),
    .req_active (req_active),
    .bit_cnt    (bit_cnt)
);

// File: tb/bitstream_rx_test.sv
module bitstream_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_bit_en = 1'b0;
    logic [7:0] cfg_clk_pol = 8'h00;
    logic       cfg_req_inv = 1'b0;
    logic       buf_pop = 1'b0;
    logic [7:0] byte_data;
    logic       byte_valid;
    logic [8:0] buf_level;
    logic       data_req;

    int n_chk  = 0;
    int n_fail = 0;
    int got_n  = 0;
    logic [7:0] got [0:1023];
    logic fall_mode = 1'b0;

    bitstream_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_bit_en(ser_bit_en), .cfg_clk_pol(cfg_clk_pol), .cfg_req_inv(cfg_req_inv),
        .buf_pop(buf_pop), .byte_data(byte_data), .byte_valid(byte_valid),
        .buf_level(buf_level), .data_req(data_req)
    );

    always #4 clk = ~clk;

    // Collect every delivered byte.
    always @(negedge clk) begin
        if (byte_valid) begin
            got[got_n % 1024] = byte_data;
            got_n = got_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic d, input logic en);
        @(negedge clk);
        ser_data = d; ser_bit_en = en;
        repeat (4) @(negedge clk);
        ser_clk = ~fall_mode;
        repeat (4) @(negedge clk);
        ser_clk = fall_mode;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i], 1'b1);
        repeat (4) @(negedge clk);
    endtask

    task automatic pop_n(input int n);
        if (n > 0) begin
            @(negedge clk); buf_pop = 1'b1;
            repeat (n) @(negedge clk);
            buf_pop = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mode(input logic [7:0] pol);
        @(negedge clk); cfg_clk_pol = pol;
        repeat (3) @(negedge clk);
        fall_mode = pol[2];
        ser_clk = pol[2];
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 level", int'(buf_level), 0);
        chk("R1 valid", int'(byte_valid), 0);
        chk("R1 req", int'(data_req), 1);
    endtask

    task automatic t_rise();
        int base = got_n;
        set_mode(8'h00);
        send_byte(8'hA5);
        send_byte(8'h3C);
        chk("R2 count", got_n - base, 2);
        chk("R2 R5 byte0", int'(got[base % 1024]), 'hA5);
        chk("R5 byte1", int'(got[(base+1) % 1024]), 'h3C);
        chk("R6 level", int'(buf_level), 2);
        set_mode(8'hFB);
        base = got_n;
        send_byte(8'h81);
        chk("R3 other bits ignored rise", int'(got[base % 1024]), 'h81);
    endtask

    task automatic t_fall();
        int base;
        set_mode(8'h04);
        base = got_n;
        send_byte(8'h96);
        chk("R3 fall count", got_n - base, 1);
        chk("R3 fall byte", int'(got[base % 1024]), 'h96);
        set_mode(8'hFF);
        base = got_n;
        send_byte(8'h5A);
        chk("R3 other bits ignored fall", int'(got[base % 1024]), 'h5A);
        set_mode(8'h00);
    endtask

    task automatic t_enable();
        int base = got_n;
        logic [7:0] b = 8'hC3;
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i], 1'b1);
            send_bit(~b[i], 1'b0);
        end
        repeat (4) @(negedge clk);
        chk("R4 count", got_n - base, 1);
        chk("R4 byte", int'(got[base % 1024]), 'hC3);
        base = got_n;
        send_byte(8'h17);
        chk("R4 alignment", int'(got[base % 1024]), 'h17);
    endtask

    task automatic t_pop();
        int lv = int'(buf_level);
        pop_n(lv + 3);
        chk("R6 pop to empty", int'(buf_level), 0);
    endtask

    task automatic t_collide();
        send_byte(8'h11);
        send_byte(8'h22);
        chk("R6 pre", int'(buf_level), 2);
        fork
            send_byte(8'h33);
            begin
                @(negedge clk iff byte_valid);
                buf_pop = 1'b1;
                @(negedge clk);
                buf_pop = 1'b0;
            end
        join
        repeat (2) @(negedge clk);
        chk("R6 push+pop nonzero", int'(buf_level), 2);
        pop_n(2);
        chk("R6 drained", int'(buf_level), 0);
        fork
            send_byte(8'h44);
            begin
                @(negedge clk iff byte_valid);
                buf_pop = 1'b1;
                @(negedge clk);
                buf_pop = 1'b0;
            end
        join
        repeat (2) @(negedge clk);
        chk("R6 push+pop empty", int'(buf_level), 1);
        pop_n(1);
    endtask

    task automatic t_partial();
        int base;
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        do_reset();
        chk("R10 R1 level", int'(buf_level), 0);
        base = got_n;
        send_byte(8'h0F);
        chk("R10 count", got_n - base, 1);
        chk("R10 byte", int'(got[base % 1024]), 'h0F);
        pop_n(1);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 251; i++) send_byte(8'(i));
        repeat (3) @(negedge clk);
        chk("R7 level 251", int'(buf_level), 251);
        chk("R7 free 5 granted", int'(data_req), 1);
        send_byte(8'hEE);
        repeat (3) @(negedge clk);
        chk("R7 free 4 withdrawn", int'(data_req), 0);
        cfg_req_inv = 1'b1;
        @(negedge clk);
        chk("R9 inverted withdrawn", int'(data_req), 1);
        cfg_req_inv = 1'b0;
        pop_n(27);
        chk("R8 level 225", int'(buf_level), 225);
        chk("R8 free 31 held", int'(data_req), 0);
        pop_n(1);
        chk("R8 free 32 granted", int'(data_req), 1);
        cfg_req_inv = 1'b1;
        @(negedge clk);
        chk("R9 inverted granted", int'(data_req), 0);
        cfg_req_inv = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(byte_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_enable();
        t_pop();
        t_collide();
        t_partial();
        t_fill();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule